// File: doc/BRIEF.md
# Mode-0 Parallel Port Interface

This block is a three-port parallel I/O peripheral that sits on a small processor bus. The bus has a 2-bit address, chip select, read and write strobes and 8-bit write and read data. Port A and port B are 8 bits wide. Port C is 8 bits wide, and its upper and lower nibbles have separate directions. Every pin has its own output-enable bit, its own output value and its own input sample, so the chip's pads can be wired directly to these ports. Only the simple I/O mode is built. Mode-select bits that ask for strobed or bidirectional operation are stored but have no effect on behaviour.

A byte written to the control address has two meanings, chosen by its top bit. When bit 7 is 1, the byte is a configuration word that sets the port directions. When bit 7 is 0, the byte is a command that sets or clears a single port C bit. The parameter `LITE` selects a cost-reduced variant. In that variant port B is always an input and port C is always an output. A configuration word leaves the output latches unchanged, and a read of the control address returns a fixed value.

Top module: `ppi_mode0`

## Requirements
- R1: After reset, in the standard variant, all output enables are 0, all output latches are 0, and a read of the control address (address 3) returns 0x9B.
- R2: A write to address 3 with bit 7 = 1 is a configuration word. Its direction bits are: bit 4 for port A, bit 1 for port B, bit 0 for the port C lower nibble and bit 3 for the port C upper nibble. A bit value of 1 means input. An output-enable bit is 1 exactly where its pin is an output. For example, 0x82 makes port A an output and port B an input, and 0x92 makes both port A and port B inputs.
- R3: In the standard variant, every configuration-word write clears the port A, B and C output latches to 0.
- R4: A write to address 3 with bit 7 = 0 stores data bit 0 into the port C latch bit selected by data bits 3..1. Data bits 6..4 are ignored. The stored configuration and the directions are left unchanged.
- R5: A write to address 0, 1 or 2 loads the latch of port A, B or C, whatever the direction of that port. The output-value pins always show the latch contents. A pin is driven only where its enable bit is 1.
- R6: A read returns data one clock after the cycle in which chip select and read are both high. An output port (or nibble) returns its latch. An input port (or nibble) returns its pins, sampled through a two-stage synchronizer. Between reads the read data holds its value.
- R7: Port C is read nibble by nibble. An input nibble returns its pins and an output nibble returns its latch, in the same read.
- R8: Configuration bits 6, 5 and 2, the mode-select fields, have no effect. For example, 0xE6 gives the same directions as 0x82.
- R9: With `LITE` = 1, port B is always an input and port C is always an output, including out of reset. A configuration word does not change any latch, and a read of the control address returns 0xFF.
- R10: When read and write are both asserted in one cycle at the same address, the read returns the value from before the write, and the write takes effect.
- R11: When port B is an output, writing 1 and then 0 to port B bit 0 drives that pin high and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin samples |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin samples |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin samples |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
Read and write can fall in the same cycle at the same address. In that case the registered read path must return the old latch value, while the latch takes the new byte. The bench provokes this with one bus cycle that has both strobes high at port A. It then judges the read data against the value written before that cycle, compares the output pins against the new byte, and confirms the new byte with a plain follow-up read. A second overlap comes from the control address itself: a configuration word clears the latches in the same edge in which it changes the directions. The bench checks both effects after that single write.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } ppi_sel_e;

  // positions of the direction bits in a configuration word (1 = input)
  localparam int CW_KIND_BIT = 7;
  localparam int DIR_A_BIT   = 4;
  localparam int DIR_B_BIT   = 1;
  localparam int DIR_CL_BIT  = 0;
  localparam int DIR_CH_BIT  = 3;

  localparam logic [7:0] CFG_AT_RESET = 8'h9B;
  localparam logic [7:0] LITE_CTL_RD  = 8'hFF;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cl_in;
    logic ch_in;
  } port_dir_t;
endpackage

// File: rtl/ppi_sync.sv
module ppi_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
#(
  parameter bit LITE = 1'b0,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cfg_q,
  output port_dir_t     dir
);
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_AT_RESET;
    else if (cfg_we) cfg_q <= wdata;
  end

  always_comb begin
    dir.a_in = cfg_q[DIR_A_BIT];
    if (LITE) begin
      dir.b_in  = 1'b1;
      dir.cl_in = 1'b0;
      dir.ch_in = 1'b0;
    end else begin
      dir.b_in  = cfg_q[DIR_B_BIT];
      dir.cl_in = cfg_q[DIR_CL_BIT];
      dir.ch_in = cfg_q[DIR_CH_BIT];
    end
  end

  // R2
  cfg_dir_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we) |-> (dir.a_in == $past(wdata[DIR_A_BIT])));
endmodule

// File: rtl/ppi_latches.sv
module ppi_latches #(
  parameter int DW           = 8,
  parameter bit CLEAR_ON_CFG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          bit_we,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          wr_c,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic [DW-1:0] c_q
);
  localparam int SELW = $clog2(DW);

  logic [SELW-1:0] bit_sel;
  assign bit_sel = wdata[SELW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
      c_q <= '0;
    end else if (cfg_we) begin
      if (CLEAR_ON_CFG) begin
        a_q <= '0;
        b_q <= '0;
        c_q <= '0;
      end
    end else if (bit_we) begin
      c_q[bit_sel] <= wdata[0];
    end else begin
      if (wr_a) a_q <= wdata;
      if (wr_b) b_q <= wdata;
      if (wr_c) c_q <= wdata;
    end
  end

  // R3
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (CLEAR_ON_CFG && $past(cfg_we)) |-> (a_q == '0 && b_q == '0 && c_q == '0));

  // R9
  cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!CLEAR_ON_CFG && $past(cfg_we)) |-> (a_q == $past(a_q) && c_q == $past(c_q)));

  // R4
  bit_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bit_we) |-> (c_q[$past(bit_sel)] == $past(wdata[0]) && a_q == $past(a_q)));
endmodule

// File: rtl/ppi_mode0.sv
module ppi_mode0
  import ppi_pkg::*;
#(
  parameter bit LITE        = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  localparam int DW  = 8;
  localparam int NIB = DW / 2;

  ppi_sel_e  sel;
  logic      we, re, cfg_we, bit_we;
  logic [DW-1:0] cfg_q, a_q, b_q, c_q, rd_val;
  logic [DW-1:0] a_s, b_s, c_s;
  port_dir_t dir;

  assign sel    = ppi_sel_e'(addr);
  assign we     = cs && wr;
  assign re     = cs && rd;
  assign cfg_we = we && (sel == SEL_CTL) &&  wdata[CW_KIND_BIT];
  assign bit_we = we && (sel == SEL_CTL) && !wdata[CW_KIND_BIT];

  ppi_ctrl #(.LITE(LITE), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .wdata(wdata),
    .cfg_q(cfg_q), .dir(dir)
  );

  ppi_latches #(.DW(DW), .CLEAR_ON_CFG(!LITE)) u_lat (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .bit_we(bit_we),
    .wr_a(we && sel == SEL_A), .wr_b(we && sel == SEL_B), .wr_c(we && sel == SEL_C),
    .wdata(wdata), .a_q(a_q), .b_q(b_q), .c_q(c_q)
  );

  ppi_sync #(.W(3*DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({pc_in, pb_in, pa_in}), .q({c_s, b_s, a_s})
  );

  assign pa_out = a_q;
  assign pb_out = b_q;
  assign pc_out = c_q;
  assign pa_oe  = {DW{~dir.a_in}};
  assign pb_oe  = {DW{~dir.b_in}};
  assign pc_oe  = {{NIB{~dir.ch_in}}, {NIB{~dir.cl_in}}};

  always_comb begin
    unique case (sel)
      SEL_A:   rd_val = dir.a_in ? a_s : a_q;
      SEL_B:   rd_val = dir.b_in ? b_s : b_q;
      SEL_C:   rd_val = {dir.ch_in ? c_s[DW-1:NIB] : c_q[DW-1:NIB],
                         dir.cl_in ? c_s[NIB-1:0]  : c_q[NIB-1:0]};
      default: rd_val = LITE ? LITE_CTL_RD : cfg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_val;
  end

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(re) |-> $stable(rdata));
endmodule

// File: tb/ppi_mode0_tb.sv
module ppi_mode0_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [7:0] l_rdata, l_pa_out, l_pa_oe, l_pb_out, l_pb_oe, l_pc_out, l_pc_oe;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ppi_mode0 #(.LITE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe));

  ppi_mode0 #(.LITE(1'b1)) u_lite (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(l_rdata), .pa_in(pa_in), .pa_out(l_pa_out), .pa_oe(l_pa_oe),
    .pb_in(pb_in), .pb_out(l_pb_out), .pb_oe(l_pb_oe),
    .pc_in(pc_in), .pc_out(l_pc_out), .pc_oe(l_pc_oe));

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v, output logic [7:0] lv);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); v = rdata; lv = l_rdata; cs = 0; rd = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v, lv;
    chk("R1", "pa_oe", pa_oe, 8'h00); chk("R1", "pb_oe", pb_oe, 8'h00);
    chk("R1", "pc_oe", pc_oe, 8'h00);
    chk("R1", "outs", pa_out | pb_out | pc_out, 8'h00);
    bus_rd(2'd3, v, lv);
    chk("R1", "ctl read", v, 8'h9B);
    chk("R9", "lite pc_oe reset", l_pc_oe, 8'hFF);
    chk("R9", "lite pb_oe reset", l_pb_oe, 8'h00);
  endtask

  task automatic t_config();
    bus_wr(2'd3, 8'h82);
    chk("R2", "0x82 pa_oe", pa_oe, 8'hFF); chk("R2", "0x82 pb_oe", pb_oe, 8'h00);
    chk("R2", "0x82 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd3, 8'h92);
    chk("R2", "0x92 pa_oe", pa_oe, 8'h00); chk("R2", "0x92 pb_oe", pb_oe, 8'h00);
    bus_wr(2'd3, 8'h89);
    chk("R2", "0x89 pc_oe", pc_oe, 8'h00); chk("R2", "0x89 pb_oe", pb_oe, 8'hFF);
  endtask

  task automatic t_clear();
    logic [7:0] v, lv;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5A); bus_wr(2'd1, 8'hC3); bus_wr(2'd2, 8'h7E);
    chk("R5", "pa_out", pa_out, 8'h5A); chk("R5", "pb_out", pb_out, 8'hC3);
    chk("R5", "pc_out", pc_out, 8'h7E);
    bus_wr(2'd3, 8'h80);
    chk("R3", "pa cleared", pa_out, 8'h00); chk("R3", "pb cleared", pb_out, 8'h00);
    chk("R3", "pc cleared", pc_out, 8'h00);
    chk("R9", "lite pa kept", l_pa_out, 8'h5A); chk("R9", "lite pb kept", l_pb_out, 8'hC3);
    chk("R9", "lite pc kept", l_pc_out, 8'h7E);
    chk("R9", "lite pb_oe", l_pb_oe, 8'h00); chk("R9", "lite pa_oe", l_pa_oe, 8'hFF);
    bus_rd(2'd3, v, lv);
    chk("R9", "lite ctl read", lv, 8'hFF);
    chk("R2", "ctl read", v, 8'h80);
  endtask

  task automatic t_bitcmd();
    logic [7:0] v, lv;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0B);
    chk("R4", "set bit5", pc_out, 8'h20);
    bus_wr(2'd3, 8'h71);
    chk("R4", "set bit0 high bits ignored", pc_out, 8'h21);
    bus_wr(2'd3, 8'h0A);
    chk("R4", "clear bit5", pc_out, 8'h01);
    chk("R4", "dir unchanged", pa_oe, 8'hFF);
    bus_rd(2'd3, v, lv);
    chk("R4", "cfg unchanged", v, 8'h80);
  endtask

  task automatic t_readback();
    logic [7:0] v, lv;
    bus_wr(2'd3, 8'h88);
    bus_wr(2'd2, 8'hA5); bus_wr(2'd0, 8'h11);
    pc_in = 8'h3C; pa_in = 8'hEE; pb_in = 8'h77;
    settle();
    bus_rd(2'd2, v, lv);
    chk("R7", "C mixed nibbles", v, 8'h35);
    bus_rd(2'd0, v, lv);
    chk("R6", "A output reads latch", v, 8'h11);
    bus_wr(2'd3, 8'h92);
    bus_rd(2'd0, v, lv);
    chk("R6", "A input reads pins", v, 8'hEE);
    bus_rd(2'd1, v, lv);
    chk("R6", "B input reads pins", v, 8'h77);
    chk("R9", "lite B reads pins", lv, 8'h77);
    pb_in = 8'h00;
    settle();
    chk("R6", "rdata holds", rdata, 8'h77);
    bus_wr(2'd0, 8'h44);
    chk("R5", "latch loads while input", pa_out, 8'h44);
    chk("R5", "not driven", pa_oe, 8'h00);
    bus_rd(2'd0, v, lv);
    chk("R5", "input read ignores latch", v, 8'hEE);
  endtask

  task automatic t_mode_bits();
    bus_wr(2'd3, 8'hE6);
    chk("R8", "pa_oe", pa_oe, 8'hFF); chk("R8", "pb_oe", pb_oe, 8'h00);
    chk("R8", "pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h3C);
    chk("R8", "pa_out", pa_out, 8'h3C);
  endtask

  task automatic t_pb0();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd1, 8'h01);
    chk("R11", "pb0 high", {7'd0, pb_out[0] & pb_oe[0]}, 8'h01);
    bus_wr(2'd1, 8'h00);
    chk("R11", "pb0 low", {7'd0, pb_out[0]}, 8'h00);
    chk("R11", "pb0 still driven", {7'd0, pb_oe[0]}, 8'h01);
  endtask

  task automatic t_same_cycle();
    logic [7:0] v, lv;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5A);
    @(negedge clk); cs = 1; rd = 1; wr = 1; addr = 2'd0; wdata = 8'h33;
    @(negedge clk); v = rdata; cs = 0; rd = 0; wr = 0;
    chk("R10", "read returns old", v, 8'h5A);
    chk("R10", "write took effect", pa_out, 8'h33);
    bus_rd(2'd0, v, lv);
    chk("R10", "follow-up read", v, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_config();
    t_clear();
    t_bitcmd();
    t_readback();
    t_mode_bits();
    t_pb0();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule